// File: doc/BRIEF.md
# Dual-Bank Programmable Interrupt Controller

This block collects 32 raw interrupt lines and turns them into two processor request outputs: a normal request (`irq_out`) and a fast request (`fiq_out`). Each output has its own bank of control registers. Both banks see the same inputs. Each line has an enable bit, a trigger-mode bit and a polarity bit in each bank. A line can therefore be level sensitive in one bank and edge sensitive in the other, or enabled in only one of them.

Inputs first pass through a two-flop synchroniser. A third flop keeps the previous synchronised value, and edges are found by comparing the two. Each bank keeps its own per-line edge latches. A latch is set by the selected edge and holds until software writes a 1 to that line's clear bit. Level lines report the polarity-adjusted input directly. Each bank's request output comes from a two-state machine. `REQ_IDLE` moves to `REQ_RAISED` when any enabled line of the bank is pending. `REQ_RAISED` returns to `REQ_IDLE` when none is pending. In every other case the state stays where it is.

The register port is a synchronous word-addressed bus. A write takes effect on the clock edge where `bus_we` is high. Read data is combinational from the word address. Word address bit 3 selects the bank (0 = normal, 1 = fast). Bits 2:0 select the register: 0 raw source, 1 enable, 2 clear, 3 trigger mode, 4 polarity, 5 masked status. Indices 6 and 7 read as zero. Bit n of every register refers to line n.

Top module: `dual_bank_intc`

## Requirements
- R1: After reset the enable, mode and polarity registers of both banks read 0, both status registers read 0, and `irq_out` and `fiq_out` are low; a bank whose enable register is 0 never raises its output.
- R2: The raw-source register (index 0, in either bank) returns the synchronised input lines before polarity adjustment; a change on `irq_lines` first shows there after two rising clock edges.
- R3: The enable (index 1), mode (index 2... see layout: index 3) and polarity (index 4) registers read back the full word last written; the normal bank is at word addresses 0-5 and the fast bank at 8-13.
- R4: A line in level mode (mode bit 0) is pending while its synchronised input is 1 with polarity bit 0, or 0 with polarity bit 1; status (index 5) is pending AND enable.
- R5: Writing the clear register has no effect on a line in level mode.
- R6: A line in edge mode (mode bit 1) with polarity 0 latches pending on a 0-to-1 transition of its synchronised input and stays pending after the input returns low.
- R7: A line in edge mode with polarity 1 latches on a 1-to-0 transition and does not latch on a 0-to-1 transition.
- R8: Writing the clear register (index 2) clears exactly the edge latches whose data bit is 1; zero bits leave latches alone; the clear register reads as 0.
- R9: An edge detected in the same cycle as a clear write of that line wins, and the line stays pending.
- R10: A request output rises on the clock edge after its bank's status becomes nonzero and falls on the clock edge after it becomes zero.
- R11: The two banks keep separate latches and enables: clearing a line in one bank leaves the other bank's pending bit and request unchanged.
- R12: An edge on a disabled line is still latched; it appears in status and raises the output once the line is enabled.
- R13: Writes to the source and status registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines | input | 32 | Raw interrupt inputs, asynchronous |
| bus_waddr | input | 4 | Word address: bit 3 bank, bits 2:0 register |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_waddr` |
| irq_out | output | 1 | Normal request, registered |
| fiq_out | output | 1 | Fast request, registered |

## Verification
Several properties are checked on every cycle, in each bank. The request state machine follows nonzero status one edge later and drops one edge after status clears. A bank with all lines disabled keeps its request low. An edge latch only ever drops when a clear bit for that line was written.

The bench scenarios cover behaviour the properties cannot see. These are the synchroniser latency, the choice of rising or falling edge by polarity, and level lines ignoring clear. They also cover the edge-versus-clear collision, latching while disabled, bank independence and writes ignored at read-only addresses.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int REG_IDX_W = 3;

    typedef enum logic [2:0] {
        RK_SOURCE,
        RK_ENABLE,
        RK_ACK,
        RK_TRIG,
        RK_POL,
        RK_STATUS,
        RK_NONE
    } reg_kind_e;

    typedef enum logic {
        REQ_IDLE,
        REQ_RAISED
    } req_state_e;

    function automatic reg_kind_e decode_kind(input logic [REG_IDX_W-1:0] idx);
        reg_kind_e k;
        case (idx)
            3'd0:    k = RK_SOURCE;
            3'd1:    k = RK_ENABLE;
            3'd2:    k = RK_ACK;
            3'd3:    k = RK_TRIG;
            3'd4:    k = RK_POL;
            3'd5:    k = RK_STATUS;
            default: k = RK_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/intc_sync_edge.sv
module intc_sync_edge #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
            prev_q   <= '0;
        end else begin
            stage1_q <= raw_in;
            stage2_q <= stage1_q;
            prev_q   <= stage2_q;
        end
    end

    always_comb begin
        lvl  = stage2_q;
        rise = stage2_q & ~prev_q;
        fall = ~stage2_q & prev_q;
    end
endmodule

// File: rtl/intc_bank.sv
module intc_bank
    import intc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] rise,
    input  logic [W-1:0] fall,
    input  logic         wr_sel,
    input  reg_kind_e    kind,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rd_word,
    output logic         req,
    output logic [W-1:0] status_o,
    output logic [W-1:0] latch_o,
    output logic [W-1:0] mode_o,
    output logic [W-1:0] enable_o,
    output logic [W-1:0] ack_o
);
    logic [W-1:0] enable_q;
    logic [W-1:0] mode_q;
    logic [W-1:0] pol_q;
    logic [W-1:0] latch_q;
    logic [W-1:0] ack_vec;
    logic [W-1:0] edge_hit;
    logic [W-1:0] pending;
    logic [W-1:0] status;
    req_state_e   req_q;
    req_state_e   req_nxt;

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
            mode_q   <= '0;
            pol_q    <= '0;
        end else if (wr_sel) begin
            case (kind)
                RK_ENABLE: enable_q <= wdata;
                RK_TRIG:   mode_q   <= wdata;
                RK_POL:    pol_q    <= wdata;
                default:   ;
            endcase
        end
    end

    always_comb begin
        ack_vec  = (wr_sel && kind == RK_ACK) ? wdata : '0;
        edge_hit = (pol_q & fall) | (~pol_q & rise);
    end

    // edge latches: a new edge outranks a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) latch_q <= '0;
        else        latch_q <= mode_q & ((latch_q & ~ack_vec) | edge_hit);
    end

    always_comb begin
        pending = (mode_q & latch_q) | (~mode_q & (lvl ^ pol_q));
        status  = pending & enable_q;
    end

    // request state machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= REQ_IDLE;
        else        req_q <= req_nxt;
    end

    always_comb begin
        req_nxt = req_q;
        unique case (req_q)
            REQ_IDLE:   if (|status)  req_nxt = REQ_RAISED;
            REQ_RAISED: if (!(|status)) req_nxt = REQ_IDLE;
        endcase
    end

    // request state machine: outputs
    always_comb begin
        req = (req_q == REQ_RAISED);
    end

    always_comb begin
        case (kind)
            RK_SOURCE: rd_word = lvl;
            RK_ENABLE: rd_word = enable_q;
            RK_TRIG:   rd_word = mode_q;
            RK_POL:    rd_word = pol_q;
            RK_STATUS: rd_word = status;
            default:   rd_word = '0;
        endcase
    end

    always_comb begin
        status_o = status;
        latch_o  = latch_q;
        mode_o   = mode_q;
        enable_o = enable_q;
        ack_o    = ack_vec;
    end
endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
    import intc_pkg::*;
#(
    parameter  int LINES     = 32,
    localparam int NUM_BANKS = 2,
    localparam int BANK_BITS = $clog2(NUM_BANKS),
    localparam int WADDR_W   = REG_IDX_W + BANK_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LINES-1:0]   irq_lines,
    input  logic [WADDR_W-1:0] bus_waddr,
    input  logic               bus_we,
    input  logic [LINES-1:0]   bus_wdata,
    output logic [LINES-1:0]   bus_rdata,
    output logic               irq_out,
    output logic               fiq_out
);
    logic [LINES-1:0] sync_lvl;
    logic [LINES-1:0] sync_rise;
    logic [LINES-1:0] sync_fall;

    reg_kind_e              acc_kind;
    logic [BANK_BITS-1:0]   acc_bank;

    logic [NUM_BANKS-1:0][LINES-1:0] bk_rd;
    logic [NUM_BANKS-1:0][LINES-1:0] bk_status;
    logic [NUM_BANKS-1:0][LINES-1:0] bk_latch;
    logic [NUM_BANKS-1:0][LINES-1:0] bk_mode;
    logic [NUM_BANKS-1:0][LINES-1:0] bk_enable;
    logic [NUM_BANKS-1:0][LINES-1:0] bk_ack;
    logic [NUM_BANKS-1:0]            bk_req;

    always_comb begin
        acc_kind = decode_kind(bus_waddr[REG_IDX_W-1:0]);
        acc_bank = bus_waddr[WADDR_W-1 -: BANK_BITS];
    end

    intc_sync_edge #(.W(LINES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_in (irq_lines),
        .lvl    (sync_lvl),
        .rise   (sync_rise),
        .fall   (sync_fall)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        intc_bank #(.W(LINES)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl      (sync_lvl),
            .rise     (sync_rise),
            .fall     (sync_fall),
            .wr_sel   (bus_we && (acc_bank == BANK_BITS'(b))),
            .kind     (acc_kind),
            .wdata    (bus_wdata),
            .rd_word  (bk_rd[b]),
            .req      (bk_req[b]),
            .status_o (bk_status[b]),
            .latch_o  (bk_latch[b]),
            .mode_o   (bk_mode[b]),
            .enable_o (bk_enable[b]),
            .ack_o    (bk_ack[b])
        );
    end

    always_comb begin
        bus_rdata = bk_rd[acc_bank];
        irq_out   = bk_req[0];
        fiq_out   = bk_req[1];
    end
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
    parameter int W  = 32,
    parameter int NB = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NB-1:0][W-1:0] bk_status,
    input logic [NB-1:0][W-1:0] bk_latch,
    input logic [NB-1:0][W-1:0] bk_mode,
    input logic [NB-1:0][W-1:0] bk_enable,
    input logic [NB-1:0][W-1:0] bk_ack,
    input logic [NB-1:0]        bk_req
);
    for (genvar b = 0; b < NB; b++) begin : g_chk
        p_req_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (|bk_status[b]) |=> bk_req[b]);

        p_req_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !(|bk_status[b]) |=> !bk_req[b]);

        p_disabled_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (bk_enable[b] == '0) |=> !bk_req[b]);

        // R8: a latch bit only drops when its clear bit was written (or mode left edge)
        p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (($past(bk_latch[b]) & ~$past(bk_ack[b]) & $past(bk_mode[b])
              & ~bk_latch[b]) == '0));
    end
endmodule

bind dual_bank_intc intc_checker #(.W(LINES), .NB(NUM_BANKS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bk_status (bk_status),
    .bk_latch  (bk_latch),
    .bk_mode   (bk_mode),
    .bk_enable (bk_enable),
    .bk_ack    (bk_ack),
    .bk_req    (bk_req)
);

// File: tb/tb_dual_bank_intc.sv
`timescale 1ns/1ps
module tb_dual_bank_intc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_lines = '0;
    logic [3:0]  bus_waddr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;
    logic        fiq_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // word addresses
    localparam logic [3:0] N_SRC = 4'd0, N_EN = 4'd1, N_CLR = 4'd2,
                           N_MODE = 4'd3, N_POL = 4'd4, N_STAT = 4'd5;
    localparam logic [3:0] F_SRC = 4'd8, F_EN = 4'd9, F_CLR = 4'd10,
                           F_MODE = 4'd11, F_POL = 4'd12, F_STAT = 4'd13;

    dual_bank_intc dut (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
        .bus_waddr(bus_waddr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out), .fiq_out(fiq_out)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    // called just after a falling edge; consumes one cycle
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_waddr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_waddr = a;
        #1 d = bus_rdata;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cleanup();
        irq_lines = '0;
        cycles(4);
        wr(N_EN, 0); wr(F_EN, 0); wr(N_POL, 0); wr(F_POL, 0);
        wr(N_MODE, 0); wr(F_MODE, 0);
        wr(N_CLR, '1); wr(F_CLR, '1);
        cycles(2);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(N_EN, v);   check("R1 irq enable", v, 0);
        rd(N_MODE, v); check("R1 irq mode", v, 0);
        rd(N_POL, v);  check("R1 irq pol", v, 0);
        rd(F_EN, v);   check("R1 fiq enable", v, 0);
        rd(F_MODE, v); check("R1 fiq mode", v, 0);
        rd(F_POL, v);  check("R1 fiq pol", v, 0);
        rd(N_STAT, v); check("R1 irq status", v, 0);
        check("R1 outputs", {30'd0, irq_out, fiq_out}, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(F_MODE, 32'h1234_5678);
        wr(F_POL, 32'hCAFE_0001);
        rd(F_MODE, v); check("R3 fiq mode readback", v, 32'h1234_5678);
        rd(F_POL, v);  check("R3 fiq pol readback", v, 32'hCAFE_0001);
        rd(N_POL, v);  check("R3 irq pol untouched", v, 0);
        wr(N_EN, 32'h8000_0001);
        rd(N_EN, v);   check("R3 irq enable readback", v, 32'h8000_0001);
        cleanup();
    endtask

    task automatic t_source();
        logic [31:0] v;
        irq_lines = 32'h8000_0041;
        @(negedge clk);
        rd(N_SRC, v); check("R2 source after one edge", v, 0);
        @(negedge clk);
        rd(N_SRC, v); check("R2 source after two edges", v, 32'h8000_0041);
        wr(N_POL, 32'hFFFF_FFFF);
        rd(N_SRC, v); check("R2 source ignores polarity", v, 32'h8000_0041);
        rd(F_SRC, v); check("R2 fiq source same lines", v, 32'h8000_0041);
        cleanup();
    endtask

    task automatic t_level();
        logic [31:0] v;
        wr(N_EN, 32'h0000_000F);
        irq_lines = 32'h0000_0002;
        cycles(4);
        rd(N_STAT, v); check("R4 active-high level", v, 32'h2);
        wr(N_POL, 32'h0000_0004);
        cycles(1);
        rd(N_STAT, v); check("R4 active-low level", v, 32'h6);
        wr(N_CLR, 32'hFFFF_FFFF);
        cycles(1);
        rd(N_STAT, v); check("R5 clear ignored for level", v, 32'h6);
        check("R4 irq_out raised", {31'd0, irq_out}, 1);
        cleanup();
    endtask

    task automatic t_out_timing();
        logic [31:0] v;
        wr(N_EN, 32'h0000_0010);
        irq_lines = 32'h10;
        cycles(2);
        rd(N_STAT, v); check("R10 status visible", v, 32'h10);
        check("R10 output not yet", {31'd0, irq_out}, 0);
        cycles(1);
        check("R10 output one edge later", {31'd0, irq_out}, 1);
        irq_lines = 0;
        cycles(2);
        rd(N_STAT, v); check("R10 status dropped", v, 0);
        check("R10 output still high", {31'd0, irq_out}, 1);
        cycles(1);
        check("R10 output dropped", {31'd0, irq_out}, 0);
        cleanup();
    endtask

    task automatic t_edge_rise();
        logic [31:0] v;
        wr(N_MODE, 32'h100); wr(N_EN, 32'h100);
        irq_lines = 32'h100; cycles(1); irq_lines = 0;
        cycles(5);
        rd(N_STAT, v); check("R6 rising edge latched", v, 32'h100);
        check("R6 irq_out high", {31'd0, irq_out}, 1);
        wr(N_CLR, 32'h0000_0000);
        rd(N_STAT, v); check("R8 zero clear no effect", v, 32'h100);
        rd(N_CLR, v);  check("R8 clear reads zero", v, 0);
        wr(N_CLR, 32'h100);
        rd(N_STAT, v); check("R8 clear bit cleared", v, 0);
        cycles(2);
        check("R8 irq_out dropped", {31'd0, irq_out}, 0);
        cleanup();
    endtask

    task automatic t_edge_fall();
        logic [31:0] v;
        wr(F_MODE, 32'h8); wr(F_POL, 32'h8); wr(F_EN, 32'h8);
        irq_lines = 32'h8;
        cycles(5);
        rd(F_STAT, v); check("R7 no latch on rise", v, 0);
        irq_lines = 0;
        cycles(5);
        rd(F_STAT, v); check("R7 falling edge latched", v, 32'h8);
        check("R7 fiq_out high, irq_out low", {30'd0, irq_out, fiq_out}, 32'h1);
        cleanup();
    endtask

    task automatic t_collision();
        logic [31:0] v;
        wr(N_MODE, 32'h1000); wr(N_EN, 32'h1000);
        irq_lines = 32'h1000; cycles(1); irq_lines = 0;
        cycles(5);
        irq_lines = 32'h1000;
        cycles(2);              // edge now detected, latched on the next edge
        wr(N_CLR, 32'h1000);    // clear lands on that same edge
        rd(N_STAT, v); check("R9 edge beats clear", v, 32'h1000);
        cleanup();
    endtask

    task automatic t_banks();
        logic [31:0] v;
        wr(N_MODE, 32'h10_0000); wr(F_MODE, 32'h10_0000);
        wr(N_EN, 32'h10_0000);   wr(F_EN, 32'h10_0000);
        irq_lines = 32'h10_0000; cycles(1); irq_lines = 0;
        cycles(5);
        wr(N_CLR, 32'h10_0000);
        cycles(2);
        rd(N_STAT, v); check("R11 irq bank cleared", v, 0);
        rd(F_STAT, v); check("R11 fiq bank kept", v, 32'h10_0000);
        check("R11 outputs", {30'd0, irq_out, fiq_out}, 32'h1);
        cleanup();
    endtask

    task automatic t_masked_and_ignored();
        logic [31:0] v;
        wr(N_MODE, 32'h200_0000);
        irq_lines = 32'h200_0000; cycles(1); irq_lines = 0;
        cycles(5);
        rd(N_STAT, v); check("R12 hidden while disabled", v, 0);
        check("R12 irq_out low", {31'd0, irq_out}, 0);
        wr(N_EN, 32'h200_0000);
        rd(N_STAT, v); check("R12 appears when enabled", v, 32'h200_0000);
        wr(N_STAT, 32'h0);
        wr(N_SRC, 32'hFFFF_FFFF);
        rd(N_STAT, v); check("R13 status write ignored", v, 32'h200_0000);
        rd(N_SRC, v);  check("R13 source write ignored", v, 0);
        rd(N_EN, v);   check("R13 enable unchanged", v, 32'h200_0000);
        check("R12 irq_out raised", {31'd0, irq_out}, 1);
        cleanup();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_source();
        t_level();
        t_out_timing();
        t_edge_rise();
        t_edge_fall();
        t_collision();
        t_banks();
        t_masked_and_ignored();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule